// File: doc/BRIEF.md
# Gate Driver Power-State Sequencer

This block is the control state machine that decides when a three-phase gate driver may drive its outputs. It watches a single enable pin, a wake pin, a sleep-select configuration bit, a boost-supply ready flag and four protection flags. From these inputs it produces a driver enable, a three-bit state code and a fault-latched flag. The analog monitors are outside the block and reach it as digital levels. All inputs are assumed to be synchronous to `clk`.

The enable pin carries three meanings, told apart by how long it stays low. A brief drop only gates the driver off. A low shorter than the long-low window that ends in a rising edge clears a latched fault, provided no protection flag is still active. A low that lasts the full window parks the block in standby, or in sleep when the sleep bit is set. Leaving standby needs a rising edge on the enable pin. The driver then waits for the boost supply to report ready, or for a timeout. Leaving sleep needs the wake pin to be held high for a minimum time.

Every time window is set in microseconds and converted to clock cycles from a clock-frequency parameter. A window that would come out as zero cycles is rounded up to one.

Top module: `gate_drv_seq`

## Requirements
- R1: After reset the state code is 1 (standby), `drv_en` is 0 and `fault_latched` is 0.
- R2: In standby, a rising edge on `oe` moves the block to start-up (code 2) on that clock. One clock after `boot_pg` is seen high, it moves to run (code 3), where `drv_en` is 1 while `oe` is high.
- R3: With `boot_pg` low, start-up lasts BOOT_CYC+1 clocks and then the block enters run. If `oe` is sampled low during start-up, the block returns to standby.
- R4: In run, `drv_en` falls once `oe` has been sampled low on OFF_CYC consecutive clocks (4 with the bench setting). When `oe` is sampled high again, `drv_en` returns to 1 on that clock and the state stays run.
- R5: In run, when `oe` has been low for LOW_CYC clocks, the next clock moves the block to standby (code 1) if `sleep_sel` is 0, or to sleep (code 0) if it is 1.
- R6: Any of `flt_oc`, `flt_ov`, `flt_uv`, `flt_ot` sampled high in run or start-up moves the block to fault (code 4) on that clock and sets `fault_latched`. A fault entered from start-up has `drv_en` at 0 at once.
- R7: After a fault is entered from run, `drv_en` stays at 1 for D clocks and then goes to 0. D is OC_CYC for overcurrent, OV_CYC for overvoltage and OTH_CYC for undervoltage or thermal (1, 3 and 5 in the bench setting). When several flags are high, overcurrent wins over overvoltage, which wins over the rest.
- R8: In fault, a rising edge on `oe` after fewer than LOW_CYC low clocks, with no flag high, returns the block to run with `fault_latched` 0 and `drv_en` 1.
- R9: That same clear pulse is ignored while any fault flag is high: the state stays fault.
- R10: In fault, an `oe` low lasting LOW_CYC clocks moves the block to standby or to sleep, as selected by `sleep_sel`, and clears `fault_latched`.
- R11: In sleep, the block moves to standby only after `wake` has been high on WAKE_CYC+1 consecutive clocks. A shorter high and any activity on `oe` leave it in sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oe | input | 1 | Output-enable pin level |
| wake | input | 1 | Wake pin level |
| sleep_sel | input | 1 | 1: a long enable low enters sleep; 0: enters standby |
| boot_pg | input | 1 | Boost supply power-good |
| flt_oc | input | 1 | Overcurrent fault flag |
| flt_ov | input | 1 | Supply overvoltage lockout flag |
| flt_uv | input | 1 | Supply undervoltage lockout flag |
| flt_ot | input | 1 | Thermal shutdown flag |
| drv_en | output | 1 | Gate driver enable |
| state_code | output | 3 | 0 sleep, 1 standby, 2 start-up, 3 run, 4 fault |
| fault_latched | output | 1 | High while a fault is latched |

## Verification
The hardest situation to reach is the turn-off delay that follows a fault. The block must first be driven into run through start-up, and the flag must then be held while `drv_en` is sampled clock by clock. The bench sweeps each fault flag, and one case with two flags high, computing the expected delay from the flag priority. In the same fault it tries a clear pulse with the flag still high, then drops the flag and repeats the pulse. The window edges are hit exactly: a low one clock short of the long-low window must clear the fault, and a wake high one clock short must leave the block asleep.

// File: rtl/drv_seq_pkg.sv
package drv_seq_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP   = 3'd0,
    ST_STANDBY = 3'd1,
    ST_START   = 3'd2,
    ST_RUN     = 3'd3,
    ST_FAULT   = 3'd4
  } pwr_state_e;

  // convert a microsecond window to clock cycles, never below one
  function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned us);
    longint unsigned c;
    c = (clk_hz * us) / 64'd1000000;
    if (c == 64'd0) c = 64'd1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/seq_run_counter.sv
module seq_run_counter #(
  parameter int unsigned MAX = 4,
  parameter int          W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;
  logic         at_max;

  assign at_max = (cnt == W'(MAX));

  always_comb begin
    cnt_d = cnt;
    if (!run)        cnt_d = '0;
    else if (!at_max) cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_max) |=> (cnt == $past(cnt) + W'(1)));

endmodule

// File: rtl/fault_delay_sel.sv
module fault_delay_sel #(
  parameter int          DW      = 3,
  parameter int unsigned OC_CYC  = 1,
  parameter int unsigned OV_CYC  = 3,
  parameter int unsigned OTH_CYC = 5
) (
  input  logic          oc,
  input  logic          ov,
  input  logic          uv,
  input  logic          ot,
  output logic [DW-1:0] dly
);

  always_comb begin
    if (oc)            dly = DW'(OC_CYC);
    else if (ov)       dly = DW'(OV_CYC);
    else if (uv || ot) dly = DW'(OTH_CYC);
    else               dly = '0;
  end

  always_comb begin
    if (oc || ov || uv || ot) begin
      // R7
      dly_nonzero_chk: assert (dly != '0);
    end
  end

endmodule

// File: rtl/gate_drv_seq.sv
module gate_drv_seq import drv_seq_pkg::*; #(
  parameter longint unsigned CLK_HZ         = 100_000_000,
  parameter int unsigned     T_OE_OFF_US    = 4,
  parameter int unsigned     T_LONG_LOW_US  = 1000,
  parameter int unsigned     T_BOOT_WAIT_US = 16000,
  parameter int unsigned     T_WAKE_US      = 150,
  parameter int unsigned     T_OC_US        = 1,
  parameter int unsigned     T_OV_US        = 3,
  parameter int unsigned     T_OTHER_US     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oe,
  input  logic       wake,
  input  logic       sleep_sel,
  input  logic       boot_pg,
  input  logic       flt_oc,
  input  logic       flt_ov,
  input  logic       flt_uv,
  input  logic       flt_ot,
  output logic       drv_en,
  output logic [2:0] state_code,
  output logic       fault_latched
);

  localparam int unsigned OFF_CYC  = us_to_cycles(CLK_HZ, T_OE_OFF_US);
  localparam int unsigned LOW_CYC  = us_to_cycles(CLK_HZ, T_LONG_LOW_US);
  localparam int unsigned BOOT_CYC = us_to_cycles(CLK_HZ, T_BOOT_WAIT_US);
  localparam int unsigned WAKE_CYC = us_to_cycles(CLK_HZ, T_WAKE_US);
  localparam int unsigned OC_CYC   = us_to_cycles(CLK_HZ, T_OC_US);
  localparam int unsigned OV_CYC   = us_to_cycles(CLK_HZ, T_OV_US);
  localparam int unsigned OTH_CYC  = us_to_cycles(CLK_HZ, T_OTHER_US);
  localparam int unsigned DLY_A    = (OC_CYC > OV_CYC) ? OC_CYC : OV_CYC;
  localparam int unsigned DLY_MAX  = (DLY_A > OTH_CYC) ? DLY_A : OTH_CYC;
  localparam int DW = $clog2(DLY_MAX + 1);
  localparam int LW = $clog2(LOW_CYC + 1);
  localparam int BW = $clog2(BOOT_CYC + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  pwr_state_e    st_q, st_d;
  logic          oe_q;
  logic [LW-1:0] low_cnt;
  logic [BW-1:0] boot_cnt;
  logic [WW-1:0] wake_cnt;
  logic [DW-1:0] off_q, off_d, sel_dly;
  logic          any_flt, long_low, boot_full, wake_full, oe_rise;
  logic          low_run, boot_run, wake_run;

  assign low_run  = !oe;
  assign boot_run = (st_q == ST_START);
  assign wake_run = (st_q == ST_SLEEP) && wake;

  seq_run_counter #(.MAX(LOW_CYC), .W(LW)) u_low_cnt (
    .clk(clk), .rst_n(rst_i_n), .run(low_run), .cnt(low_cnt));

  seq_run_counter #(.MAX(BOOT_CYC), .W(BW)) u_boot_cnt (
    .clk(clk), .rst_n(rst_i_n), .run(boot_run), .cnt(boot_cnt));

  seq_run_counter #(.MAX(WAKE_CYC), .W(WW)) u_wake_cnt (
    .clk(clk), .rst_n(rst_i_n), .run(wake_run), .cnt(wake_cnt));

  fault_delay_sel #(.DW(DW), .OC_CYC(OC_CYC), .OV_CYC(OV_CYC), .OTH_CYC(OTH_CYC)) u_dly_sel (
    .oc(flt_oc), .ov(flt_ov), .uv(flt_uv), .ot(flt_ot), .dly(sel_dly));

  assign any_flt   = flt_oc || flt_ov || flt_uv || flt_ot;
  assign long_low  = (low_cnt == LW'(LOW_CYC));
  assign boot_full = (boot_cnt == BW'(BOOT_CYC));
  assign wake_full = (wake_cnt == WW'(WAKE_CYC));
  assign oe_rise   = oe && !oe_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_SLEEP:   if (wake && wake_full) st_d = ST_STANDBY;
      ST_STANDBY: if (oe_rise) st_d = ST_START;
      ST_START: begin
        if (any_flt)                   st_d = ST_FAULT;
        else if (!oe)                  st_d = ST_STANDBY;
        else if (boot_pg || boot_full) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (any_flt)       st_d = ST_FAULT;
        else if (long_low) st_d = sleep_sel ? ST_SLEEP : ST_STANDBY;
      end
      ST_FAULT: begin
        if (long_low)                 st_d = sleep_sel ? ST_SLEEP : ST_STANDBY;
        else if (oe_rise && !any_flt) st_d = ST_RUN;
      end
      default: st_d = ST_STANDBY;
    endcase
  end

  always_comb begin
    off_d = off_q;
    if (st_q == ST_RUN && any_flt)          off_d = sel_dly;
    else if (st_q == ST_FAULT && off_q != '0) off_d = off_q - DW'(1);
    else if (st_q != ST_FAULT)               off_d = '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q  <= ST_STANDBY;
      oe_q  <= 1'b0;
      off_q <= '0;
    end else begin
      st_q  <= st_d;
      oe_q  <= oe;
      off_q <= off_d;
    end
  end

  assign drv_en = ((st_q == ST_RUN) && (low_cnt < LW'(OFF_CYC))) ||
                  ((st_q == ST_FAULT) && (off_q != '0));
  assign state_code    = st_q;
  assign fault_latched = (st_q == ST_FAULT);

  // R6
  flt_entry_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((st_q == ST_RUN || st_q == ST_START) && any_flt) |=> (st_q == ST_FAULT));

  // R9
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_FAULT && any_flt && !long_low) |=> (st_q == ST_FAULT));

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_SLEEP && !wake) |=> (st_q == ST_SLEEP));

  // R5
  long_low_exit_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_RUN && !any_flt && long_low) |=>
      (st_q == ($past(sleep_sel) ? ST_SLEEP : ST_STANDBY)));

  // R7
  flt_delay_start_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($rose(st_q == ST_FAULT) && $past(st_q == ST_RUN)) |-> drv_en);

endmodule

// File: tb/gate_drv_seq_test.sv
module gate_drv_seq_test;

  localparam longint unsigned HZ = 1_000_000;
  localparam int OFF  = int'(HZ * 4 / 1000000);
  localparam int LOW  = int'(HZ * 1000 / 1000000);
  localparam int BOOT = int'(HZ * 16000 / 1000000);
  localparam int WAKE = int'(HZ * 150 / 1000000);
  localparam int D_OC = int'(HZ * 1 / 1000000);
  localparam int D_OV = int'(HZ * 3 / 1000000);
  localparam int D_OT = int'(HZ * 5 / 1000000);

  logic clk = 1'b0;
  logic rst_n, oe, wake, sleep_sel, boot_pg, flt_oc, flt_ov, flt_uv, flt_ot;
  logic drv_en, fault_latched;
  logic [2:0] state_code;
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gate_drv_seq #(.CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .oe(oe), .wake(wake), .sleep_sel(sleep_sel),
    .boot_pg(boot_pg), .flt_oc(flt_oc), .flt_ov(flt_ov), .flt_uv(flt_uv),
    .flt_ot(flt_ot), .drv_en(drv_en), .state_code(state_code),
    .fault_latched(fault_latched));

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] est,
                       input logic edrv, input logic efl);
    n_cmp++;
    if (state_code !== est || drv_en !== edrv || fault_latched !== efl) begin
      n_bad++;
      $display("FAIL %s: state=%0d drv=%0b flt=%0b expected state=%0d drv=%0b flt=%0b",
               req, state_code, drv_en, fault_latched, est, edrv, efl);
    end
  endtask

  // from standby with oe low, through start-up into run
  task automatic to_run();
    oe = 1'b0; step(1);
    boot_pg = 1'b1; oe = 1'b1; step(1);
    check("R2 start-up", 3'd2, 1'b0, 1'b0);
    step(1);
    check("R2 run", 3'd3, 1'b1, 1'b0);
    boot_pg = 1'b0;
  endtask

  initial begin
    #(10 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; oe = 1'b0; wake = 1'b0; sleep_sel = 1'b0; boot_pg = 1'b0;
    flt_oc = 1'b0; flt_ov = 1'b0; flt_uv = 1'b0; flt_ot = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
    check("R1 reset", 3'd1, 1'b0, 1'b0);

    to_run();

    // R4: short enable low gates the driver only
    oe = 1'b0; step(OFF - 1);
    check("R4 before off", 3'd3, 1'b1, 1'b0);
    step(1);
    check("R4 off", 3'd3, 1'b0, 1'b0);
    oe = 1'b1; step(1);
    check("R4 back on", 3'd3, 1'b1, 1'b0);

    // R5: long low to standby
    sleep_sel = 1'b0;
    oe = 1'b0; step(LOW);
    check("R5 window edge", 3'd3, 1'b0, 1'b0);
    step(1);
    check("R5 standby", 3'd1, 1'b0, 1'b0);

    // R3: boost timeout
    boot_pg = 1'b0; oe = 1'b1; step(1);
    check("R3 start-up", 3'd2, 1'b0, 1'b0);
    step(BOOT);
    check("R3 still waiting", 3'd2, 1'b0, 1'b0);
    step(1);
    check("R3 timeout run", 3'd3, 1'b1, 1'b0);
    oe = 1'b0; step(LOW + 1);
    oe = 1'b1; step(1);
    oe = 1'b0; step(1);
    check("R3 abort to standby", 3'd1, 1'b0, 1'b0);

    // R6 R7 R8 R9: sweep fault types, expected delay by priority
    for (int k = 0; k < 5; k++) begin
      int d;
      to_run();
      flt_oc = (k == 0) || (k == 4);
      flt_ov = (k == 1);
      flt_uv = (k == 2);
      flt_ot = (k == 3) || (k == 4);
      d = flt_oc ? D_OC : (flt_ov ? D_OV : D_OT);
      step(1);
      check("R6 fault entry", 3'd4, 1'b1, 1'b1);
      step(d - 1);
      check("R7 delay last on", 3'd4, 1'b1, 1'b1);
      step(1);
      check("R7 delay off", 3'd4, 1'b0, 1'b1);
      oe = 1'b0; step(3); oe = 1'b1; step(1);
      check("R9 clear ignored", 3'd4, 1'b0, 1'b1);
      flt_oc = 1'b0; flt_ov = 1'b0; flt_uv = 1'b0; flt_ot = 1'b0;
      oe = 1'b0; step(3); oe = 1'b1; step(1);
      check("R8 cleared", 3'd3, 1'b1, 1'b0);
      oe = 1'b0; step(LOW + 1);
      check("R5 standby again", 3'd1, 1'b0, 1'b0);
    end

    // R6 from start-up, then R8 at the window boundary
    boot_pg = 1'b0; oe = 1'b1; step(1);
    check("R6 start-up", 3'd2, 1'b0, 1'b0);
    flt_uv = 1'b1; step(1);
    check("R6 fault from start-up", 3'd4, 1'b0, 1'b1);
    flt_uv = 1'b0;
    oe = 1'b0; step(LOW - 1); oe = 1'b1; step(1);
    check("R8 longest short pulse", 3'd3, 1'b1, 1'b0);

    // R10: long low in fault goes to sleep
    flt_ot = 1'b1; step(1); flt_ot = 1'b0; step(6);
    sleep_sel = 1'b1;
    oe = 1'b0; step(LOW);
    check("R10 window edge", 3'd4, 1'b0, 1'b1);
    step(1);
    check("R10 sleep", 3'd0, 1'b0, 1'b0);

    // R11: sleep exit rules
    oe = 1'b1; step(3); oe = 1'b0; step(2);
    check("R11 oe ignored", 3'd0, 1'b0, 1'b0);
    wake = 1'b1; step(WAKE - 1); wake = 1'b0; step(1);
    check("R11 short wake", 3'd0, 1'b0, 1'b0);
    wake = 1'b1; step(WAKE);
    check("R11 wake edge", 3'd0, 1'b0, 1'b0);
    step(1);
    check("R11 wake standby", 3'd1, 1'b0, 1'b0);
    wake = 1'b0;

    // R5: long low in run with sleep selected
    to_run();
    oe = 1'b0; step(LOW + 1);
    check("R5 sleep", 3'd0, 1'b0, 1'b0);
    sleep_sel = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule